// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects 64 interrupt request lines and decides, every clock, which one the processor core should take next. Software assigns each line a two-bit priority level through a small register bus; a level of zero switches the line off. Among the lines that are asserted, the block finds the highest level in use and, inside that level, the line with the lowest number. The winner is compared with the core's current mask level, and an interrupt request goes out with the address the core should jump to.

The jump address is normally a programmable vector base plus twice the source number. Two fast-interrupt slots can each name a source and a directly programmed address; when the winner matches an enabled slot, the slot's address is used instead. While the system sits in a low-power state, a qualifying interrupt also raises a wake output so that the clock controller can restart the clocks. A separate register holds the address the core fetches first after reset, and this value is driven out continuously.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Each source has a 2-bit level. Register address k (0 to 7) holds sources 8k to 8k+7, with source 8k+i at data bits [2i+1:2i]. Written levels read back unchanged through `reg_rdata_o`, which shows the register at `reg_addr_i` combinationally.
- R2: Sources marked in `FIXED_MASK` (by default sources 0 and 1) are held at level 3 from reset onward. Writes to their fields are ignored, and their fields read back as 3.
- R3: A source at level 0 never produces an interrupt, whatever its request line does.
- R4: Across levels, the higher level wins. Within a level, the asserted source with the lowest number wins, and `src_o` reports that number.
- R5: `irq_o` is high only when the winning level is strictly greater than `core_lvl_i`.
- R6: Register address 8 holds the vector base. Without a fast-slot match, `vec_o` equals the base plus two times the winning source number, modulo 2^16.
- R7: Register addresses 9 and 11 configure slots 0 and 1: bit 15 is the enable and bits [5:0] the source. Addresses 10 and 12 hold the slot addresses. When an enabled slot names the winner, `vec_o` carries that slot's address and `fast_o` is high. Slot 0 takes precedence over slot 1.
- R8: `wake_o` is high exactly when `low_power_i` was high and an interrupt was raised in that same evaluation.
- R9: `reset_vec_o` equals `RESET_VEC_INIT` (default 0x0400) after reset. A write to address 13 replaces it from the next cycle.
- R10: All core-side outputs are registered. They reflect the request lines, mask level and configuration as sampled at the previous clock edge. During reset, and whenever `irq_o` is low, `vec_o`, `src_o`, `fast_o` and `wake_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data for the addressed register |
| irq_lines_i | input | 64 | Interrupt request lines, one per source |
| core_lvl_i | input | 2 | Core's current mask level |
| low_power_i | input | 1 | High while clocks are stopped or slowed |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 16 | Jump address for the pending interrupt |
| src_o | output | 6 | Winning source number |
| fast_o | output | 1 | Winner was redirected by a fast slot |
| wake_o | output | 1 | Clock restart request |
| reset_vec_o | output | 16 | Initial fetch address |

## Verification
A corrupted level field shows up at `reg_rdata_o` as soon as that register is addressed. It shows up on `irq_o`, `src_o` and `vec_o` one clock after its source is asserted on its own. A fault in the per-level encoders or in the level selection gives a wrong `src_o` or a missing `irq_o` one clock after the offending request pattern. For this reason, every single source is swept against all four mask levels, and mixed patterns are compared with an arithmetic model. A stale fast-slot or base register gives a wrong `vec_o` on the first interrupt that uses it.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int LVL_W  = 2;
    localparam int DATA_W = 16;
    localparam int NUM_LVL = 1 << LVL_W;
    localparam int SLOT_EN_BIT = DATA_W - 1;

    typedef enum logic [LVL_W-1:0] {
        LVL_OFF  = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_MID  = 2'd2,
        LVL_HIGH = 2'd3
    } lvl_t;
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int SRC_W    = 6,
    parameter int NUM_FAST = 2,
    parameter int REG_AW   = 4,
    parameter logic [NUM_SRC-1:0] FIXED_MASK = 64'h3,
    parameter logic [DATA_W-1:0]  RESET_VEC_INIT = 16'h0400
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_i,
    input  logic [REG_AW-1:0]                   addr_i,
    input  logic [DATA_W-1:0]                   wdata_i,
    output logic [DATA_W-1:0]                   rdata_o,
    output lvl_t [NUM_SRC-1:0]                  prio_o,
    output logic [DATA_W-1:0]                   base_o,
    output logic [NUM_FAST-1:0]                 slot_en_o,
    output logic [NUM_FAST-1:0][SRC_W-1:0]      slot_src_o,
    output logic [NUM_FAST-1:0][DATA_W-1:0]     slot_addr_o,
    output logic [DATA_W-1:0]                   reset_vec_o
);
    localparam int FIELDS        = DATA_W / LVL_W;
    localparam int NUM_PRIO_REGS = NUM_SRC / FIELDS;
    localparam int ADDR_BASE     = NUM_PRIO_REGS;
    localparam int ADDR_SLOT     = NUM_PRIO_REGS + 1;
    localparam int ADDR_RSTV     = ADDR_SLOT + 2 * NUM_FAST;

    typedef struct packed {
        lvl_t [NUM_SRC-1:0]              prio;
        logic [DATA_W-1:0]               base;
        logic [NUM_FAST-1:0]             slot_en;
        logic [NUM_FAST-1:0][SRC_W-1:0]  slot_src;
        logic [NUM_FAST-1:0][DATA_W-1:0] slot_addr;
        logic [DATA_W-1:0]               rst_vec;
    } cfg_t;

    function automatic cfg_t reset_cfg();
        cfg_t c;
        c = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            c.prio[s] = FIXED_MASK[s] ? LVL_HIGH : LVL_OFF;
        end
        c.rst_vec = RESET_VEC_INIT;
        return c;
    endfunction

    cfg_t cfg_d, cfg_q;

    // Next-state: decode the write, keep hard-wired sources at the top level.
    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (addr_i == REG_AW'(s / FIELDS)) begin
                    cfg_d.prio[s] = lvl_t'(wdata_i[(s % FIELDS) * LVL_W +: LVL_W]);
                end
            end
            if (addr_i == REG_AW'(ADDR_BASE)) begin
                cfg_d.base = wdata_i;
            end
            for (int k = 0; k < NUM_FAST; k++) begin
                if (addr_i == REG_AW'(ADDR_SLOT + 2 * k)) begin
                    cfg_d.slot_en[k]  = wdata_i[SLOT_EN_BIT];
                    cfg_d.slot_src[k] = wdata_i[SRC_W-1:0];
                end
                if (addr_i == REG_AW'(ADDR_SLOT + 2 * k + 1)) begin
                    cfg_d.slot_addr[k] = wdata_i;
                end
            end
            if (addr_i == REG_AW'(ADDR_RSTV)) begin
                cfg_d.rst_vec = wdata_i;
            end
        end
        for (int s = 0; s < NUM_SRC; s++) begin
            if (FIXED_MASK[s]) begin
                cfg_d.prio[s] = LVL_HIGH;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= reset_cfg();
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Read mux.
    always_comb begin
        rdata_o = '0;
        for (int r = 0; r < NUM_PRIO_REGS; r++) begin
            if (addr_i == REG_AW'(r)) begin
                for (int i = 0; i < FIELDS; i++) begin
                    rdata_o[i * LVL_W +: LVL_W] = cfg_q.prio[r * FIELDS + i];
                end
            end
        end
        if (addr_i == REG_AW'(ADDR_BASE)) begin
            rdata_o = cfg_q.base;
        end
        for (int k = 0; k < NUM_FAST; k++) begin
            if (addr_i == REG_AW'(ADDR_SLOT + 2 * k)) begin
                rdata_o = '0;
                rdata_o[SLOT_EN_BIT]  = cfg_q.slot_en[k];
                rdata_o[SRC_W-1:0]    = cfg_q.slot_src[k];
            end
            if (addr_i == REG_AW'(ADDR_SLOT + 2 * k + 1)) begin
                rdata_o = cfg_q.slot_addr[k];
            end
        end
        if (addr_i == REG_AW'(ADDR_RSTV)) begin
            rdata_o = cfg_q.rst_vec;
        end
    end

    assign prio_o      = cfg_q.prio;
    assign base_o      = cfg_q.base;
    assign slot_en_o   = cfg_q.slot_en;
    assign slot_src_o  = cfg_q.slot_src;
    assign slot_addr_o = cfg_q.slot_addr;
    assign reset_vec_o = cfg_q.rst_vec;

    // R2: hard-wired sources never leave the top level.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_fixed_chk
        if (FIXED_MASK[s]) begin : g_on
            assert_fixed_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
                prio_o[s] == LVL_HIGH);
        end
    end

    // R6: a base write lands on the next cycle.
    assert_base_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == REG_AW'(ADDR_BASE)) |=> base_o == $past(wdata_i));

    // R9: a reset-vector write lands on the next cycle.
    assert_rstvec_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == REG_AW'(ADDR_RSTV)) |=> reset_vec_o == $past(wdata_i));
endmodule

// File: rtl/prio_irq_lvl_enc.sv
module prio_irq_lvl_enc #(
    parameter int N     = 64,
    parameter int IDX_W = 6
) (
    input  logic [N-1:0]     req_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    // Lowest asserted index wins.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
        valid_o = |req_i;
    end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int SRC_W    = 6,
    parameter int NUM_FAST = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_SRC-1:0]               irq_i,
    input  lvl_t [NUM_SRC-1:0]               prio_i,
    input  logic [LVL_W-1:0]                 core_lvl_i,
    input  logic                             low_power_i,
    input  logic [DATA_W-1:0]                base_i,
    input  logic [NUM_FAST-1:0]              slot_en_i,
    input  logic [NUM_FAST-1:0][SRC_W-1:0]   slot_src_i,
    input  logic [NUM_FAST-1:0][DATA_W-1:0]  slot_addr_i,
    output logic                             irq_o,
    output logic [DATA_W-1:0]                vec_o,
    output logic [SRC_W-1:0]                 src_o,
    output logic                             fast_o,
    output logic                             wake_o
);
    typedef struct packed {
        logic              irq;
        lvl_t              lvl;
        logic [SRC_W-1:0]  src;
        logic [DATA_W-1:0] vec;
        logic              fast;
        logic              wake;
    } out_t;

    logic [NUM_LVL-1:1][NUM_SRC-1:0] req_l;
    logic [NUM_LVL-1:1]              lvl_valid;
    logic [NUM_LVL-1:1][SRC_W-1:0]   lvl_idx;

    // Split the request lines by their programmed level.
    always_comb begin
        for (int l = 1; l < NUM_LVL; l++) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                req_l[l][s] = irq_i[s] && (prio_i[s] == lvl_t'(l));
            end
        end
    end

    for (genvar l = 1; l < NUM_LVL; l++) begin : g_lvl
        prio_irq_lvl_enc #(
            .N     (NUM_SRC),
            .IDX_W (SRC_W)
        ) u_enc (
            .req_i   (req_l[l]),
            .valid_o (lvl_valid[l]),
            .idx_o   (lvl_idx[l])
        );

        // R4: the encoder points at an asserted request with none below it.
        assert_enc_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_valid[l] |-> req_l[l][lvl_idx[l]]);
        assert_enc_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_valid[l] |-> ((req_l[l] & ((NUM_SRC'(1) << lvl_idx[l]) - NUM_SRC'(1))) == '0));
    end

    lvl_t              win_lvl;
    logic [SRC_W-1:0]  win_idx;
    logic              qual;
    logic              hit;
    logic [DATA_W-1:0] hit_addr;
    out_t              st_d, st_q;

    always_comb begin
        win_lvl = LVL_OFF;
        win_idx = '0;
        for (int l = 1; l < NUM_LVL; l++) begin
            if (lvl_valid[l]) begin
                win_lvl = lvl_t'(l);
                win_idx = lvl_idx[l];
            end
        end
        qual = (win_lvl != LVL_OFF) && (win_lvl > core_lvl_i);

        hit      = 1'b0;
        hit_addr = '0;
        for (int k = NUM_FAST - 1; k >= 0; k--) begin
            if (slot_en_i[k] && slot_src_i[k] == win_idx) begin
                hit      = 1'b1;
                hit_addr = slot_addr_i[k];
            end
        end

        st_d = '0;
        if (qual) begin
            st_d.irq  = 1'b1;
            st_d.lvl  = win_lvl;
            st_d.src  = win_idx;
            st_d.fast = hit;
            st_d.vec  = hit ? hit_addr : base_i + (DATA_W'(win_idx) << 1);
            st_d.wake = low_power_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o  = st_q.irq;
    assign vec_o  = st_q.vec;
    assign src_o  = st_q.src;
    assign fast_o = st_q.fast;
    assign wake_o = st_q.wake;

    assert_irq_above_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> (st_q.lvl != LVL_OFF) && (st_q.lvl > $past(core_lvl_i)));
    assert_plain_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !st_q.fast) |-> st_q.vec == $past(base_i) + (DATA_W'(st_q.src) << 1));
    assert_fast_needs_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fast |-> st_q.irq);
    assert_wake_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wake |-> (st_q.irq && $past(low_power_i)));
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.irq |-> (st_q.vec == '0 && st_q.src == '0 && !st_q.fast && !st_q.wake));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_FAST = 2,
    parameter int REG_AW   = 4,
    parameter logic [NUM_SRC-1:0] FIXED_MASK = 64'h3,
    parameter logic [DATA_W-1:0]  RESET_VEC_INIT = 16'h0400
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr_i,
    input  logic [REG_AW-1:0]          reg_addr_i,
    input  logic [DATA_W-1:0]          reg_wdata_i,
    output logic [DATA_W-1:0]          reg_rdata_o,
    input  logic [NUM_SRC-1:0]         irq_lines_i,
    input  logic [LVL_W-1:0]           core_lvl_i,
    input  logic                       low_power_i,
    output logic                       irq_o,
    output logic [DATA_W-1:0]          vec_o,
    output logic [$clog2(NUM_SRC)-1:0] src_o,
    output logic                       fast_o,
    output logic                       wake_o,
    output logic [DATA_W-1:0]          reset_vec_o
);
    localparam int SRC_W = $clog2(NUM_SRC);

    lvl_t [NUM_SRC-1:0]              prio;
    logic [DATA_W-1:0]               base;
    logic [NUM_FAST-1:0]             slot_en;
    logic [NUM_FAST-1:0][SRC_W-1:0]  slot_src;
    logic [NUM_FAST-1:0][DATA_W-1:0] slot_addr;

    prio_irq_regs #(
        .NUM_SRC        (NUM_SRC),
        .SRC_W          (SRC_W),
        .NUM_FAST       (NUM_FAST),
        .REG_AW         (REG_AW),
        .FIXED_MASK     (FIXED_MASK),
        .RESET_VEC_INIT (RESET_VEC_INIT)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (reg_wr_i),
        .addr_i      (reg_addr_i),
        .wdata_i     (reg_wdata_i),
        .rdata_o     (reg_rdata_o),
        .prio_o      (prio),
        .base_o      (base),
        .slot_en_o   (slot_en),
        .slot_src_o  (slot_src),
        .slot_addr_o (slot_addr),
        .reset_vec_o (reset_vec_o)
    );

    prio_irq_arb #(
        .NUM_SRC  (NUM_SRC),
        .SRC_W    (SRC_W),
        .NUM_FAST (NUM_FAST)
    ) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (irq_lines_i),
        .prio_i      (prio),
        .core_lvl_i  (core_lvl_i),
        .low_power_i (low_power_i),
        .base_i      (base),
        .slot_en_i   (slot_en),
        .slot_src_i  (slot_src),
        .slot_addr_i (slot_addr),
        .irq_o       (irq_o),
        .vec_o       (vec_o),
        .src_o       (src_o),
        .fast_o      (fast_o),
        .wake_o      (wake_o)
    );
endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [3:0]  reg_addr_i = '0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic [63:0] irq_lines_i = '0;
    logic [1:0]  core_lvl_i = '0;
    logic        low_power_i = 1'b0;
    logic        irq_o, fast_o, wake_o;
    logic [15:0] vec_o, reset_vec_o;
    logic [5:0]  src_o;

    always #2.5 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_lines_i(irq_lines_i),
        .core_lvl_i(core_lvl_i), .low_power_i(low_power_i), .irq_o(irq_o), .vec_o(vec_o),
        .src_o(src_o), .fast_o(fast_o), .wake_o(wake_o), .reset_vec_o(reset_vec_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench model of the programmed configuration.
    int          lvl_m [64];
    logic [15:0] base_m = '0;
    bit          sen_m [2];
    int          ssrc_m [2];
    logic [15:0] saddr_m [2];
    logic [31:0] rng = 32'h1234_5678;

    function automatic bit is_fixed(int s);
        return (s == 0) || (s == 1);
    endfunction

    function automatic logic [31:0] next_rng(logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        reg_addr_i = 4'(a);
        reg_wdata_i = d;
        reg_wr_i = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0;
        if (a < 8) begin
            for (int i = 0; i < 8; i++) begin
                if (!is_fixed(a * 8 + i)) lvl_m[a * 8 + i] = int'(d[2 * i +: 2]);
            end
        end else if (a == 8) base_m = d;
        else if (a == 9 || a == 11) begin
            sen_m[(a - 9) / 2] = d[15];
            ssrc_m[(a - 9) / 2] = int'(d[5:0]);
        end else if (a == 10 || a == 12) saddr_m[(a - 10) / 2] = d;
    endtask

    function automatic logic [15:0] prio_word(int r);
        logic [15:0] w;
        w = '0;
        for (int i = 0; i < 8; i++) w[2 * i +: 2] = 2'(lvl_m[r * 8 + i]);
        return w;
    endfunction

    // Expected outputs from the requirements: top level, then lowest number.
    task automatic check_out(input string ctx);
        int wl, ws, hs;
        bit e_irq, e_fast, e_wake;
        logic [15:0] e_vec;
        wl = 0; ws = 0;
        for (int s = 0; s < 64; s++) begin
            if (irq_lines_i[s] && lvl_m[s] > wl) begin
                wl = lvl_m[s];
                ws = s;
            end
        end
        e_irq = (wl > int'(core_lvl_i));
        hs = -1;
        for (int k = 1; k >= 0; k--) if (sen_m[k] && ssrc_m[k] == ws) hs = k;
        e_fast = e_irq && (hs >= 0);
        e_vec = !e_irq ? 16'h0 : (hs >= 0) ? saddr_m[hs] : 16'(base_m + 16'(2 * ws));
        e_wake = e_irq && low_power_i;
        chk(irq_o == e_irq, {"R5 irq ", ctx}, 64'(irq_o), 64'(e_irq));
        chk(src_o == (e_irq ? 6'(ws) : 6'd0), {"R4 src ", ctx}, 64'(src_o), 64'(e_irq ? ws : 0));
        chk(vec_o == e_vec, {"R6 vec ", ctx}, 64'(vec_o), 64'(e_vec));
        chk(fast_o == e_fast, {"R7 fast ", ctx}, 64'(fast_o), 64'(e_fast));
        chk(wake_o == e_wake, {"R8 wake ", ctx}, 64'(wake_o), 64'(e_wake));
    endtask

    task automatic drive(input logic [63:0] lines, input int m, input bit lp);
        irq_lines_i = lines;
        core_lvl_i = 2'(m);
        low_power_i = lp;
        @(negedge clk);
    endtask

    task automatic program_pattern();
        for (int r = 0; r < 8; r++) begin
            logic [15:0] d;
            for (int i = 0; i < 8; i++) d[2 * i +: 2] = 2'(((r * 8 + i) % 3) + 1);
            wr(r, d);
        end
    endtask

    initial begin
        for (int s = 0; s < 64; s++) lvl_m[s] = is_fixed(s) ? 3 : 0;
        for (int k = 0; k < 2; k++) begin sen_m[k] = 0; ssrc_m[k] = 0; saddr_m[k] = '0; end

        repeat (3) @(negedge clk);
        // R10 / R9: state during reset.
        chk(irq_o == 1'b0 && vec_o == '0 && src_o == '0 && !fast_o && !wake_o,
            "R10 reset outputs", 64'({irq_o, vec_o, src_o, fast_o, wake_o}), 64'(0));
        chk(reset_vec_o == 16'h0400, "R9 reset vector", 64'(reset_vec_o), 64'h0400);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: fixed sources read as level 3 and ignore writes.
        reg_addr_i = 4'd0; #1;
        chk(reg_rdata_o == 16'h000F, "R2 fixed reset readback", 64'(reg_rdata_o), 64'h000F);
        wr(0, 16'h0000);
        reg_addr_i = 4'd0; #1;
        chk(reg_rdata_o == 16'h000F, "R2 fixed write ignored", 64'(reg_rdata_o), 64'h000F);
        drive(64'h1, 2, 0);
        chk(irq_o == 1'b1 && src_o == 6'd0, "R2 fixed source above mask 2", 64'(irq_o), 64'd1);

        // R1: program levels and read them back.
        program_pattern();
        for (int r = 0; r < 8; r++) begin
            reg_addr_i = 4'(r); #1;
            chk(reg_rdata_o == prio_word(r), "R1 level readback", 64'(reg_rdata_o), 64'(prio_word(r)));
        end
        wr(8, 16'h1000);

        // R4/R5/R6: every single source against every mask level.
        for (int s = 0; s < 64; s++) begin
            for (int m = 0; m < 4; m++) begin
                drive(64'(1) << s, m, 0);
                check_out("single sweep");
            end
        end

        // R4: two equal-level sources, lower number wins; higher level beats lower number.
        drive((64'(1) << 5) | (64'(1) << 8), 0, 0);
        chk(src_o == 6'd5, "R4 tie lower number", 64'(src_o), 64'd5);
        drive((64'(1) << 4) | (64'(1) << 5), 0, 0);
        chk(src_o == 6'd5, "R4 higher level wins", 64'(src_o), 64'd5);

        // R3: level zero silences sources 16..23.
        wr(2, 16'h0000);
        drive(64'hFF << 16, 0, 0);
        chk(irq_o == 1'b0, "R3 disabled sources", 64'(irq_o), 64'd0);

        // R10: output changes one edge after the input.
        irq_lines_i = 64'(1) << 5;
        core_lvl_i = 2'd0;
        #1;
        chk(irq_o == 1'b0, "R10 not yet registered", 64'(irq_o), 64'd0);
        @(negedge clk);
        chk(irq_o == 1'b1 && src_o == 6'd5, "R10 registered next edge", 64'(src_o), 64'd5);

        // R7: fast slots.
        program_pattern();
        wr(9, 16'h8000 | 16'd10);
        wr(10, 16'hABCD);
        drive(64'(1) << 10, 0, 0);
        chk(fast_o == 1'b1 && vec_o == 16'hABCD, "R7 slot0 redirect", 64'(vec_o), 64'hABCD);
        wr(11, 16'h8000 | 16'd10);
        wr(12, 16'h5555);
        drive(64'(1) << 10, 0, 0);
        chk(vec_o == 16'hABCD, "R7 slot0 precedence", 64'(vec_o), 64'hABCD);
        wr(9, 16'd10);
        drive(64'(1) << 10, 0, 0);
        chk(vec_o == 16'h5555 && fast_o, "R7 slot1 after slot0 disabled", 64'(vec_o), 64'h5555);
        drive(64'(1) << 11, 0, 0);
        chk(fast_o == 1'b0 && vec_o == 16'h1016, "R7 unmatched source", 64'(vec_o), 64'h1016);

        // R8: wake only with a qualifying interrupt in low power.
        drive(64'(1) << 10, 0, 1);
        chk(wake_o == 1'b1, "R8 wake raised", 64'(wake_o), 64'd1);
        drive(64'(1) << 10, 3, 1);
        chk(wake_o == 1'b0, "R8 masked no wake", 64'(wake_o), 64'd0);
        drive(64'(1) << 10, 0, 0);
        chk(wake_o == 1'b0, "R8 awake no wake", 64'(wake_o), 64'd0);

        // R9: reset vector rewrite.
        wr(13, 16'h2468);
        chk(reset_vec_o == 16'h2468, "R9 reset vector write", 64'(reset_vec_o), 64'h2468);

        // R4..R8 mixed patterns against the model.
        wr(9, 16'h8000 | 16'd33);
        wr(10, 16'h7F00);
        for (int it = 0; it < 400; it++) begin
            logic [63:0] a, b;
            rng = next_rng(rng);
            if (rng[3:0] == 4'd0) begin
                int r;
                r = int'(rng[6:4]);
                rng = next_rng(rng);
                wr(r, rng[15:0]);
            end
            rng = next_rng(rng); a[31:0] = rng;
            rng = next_rng(rng); a[63:32] = rng;
            rng = next_rng(rng); b[31:0] = rng;
            rng = next_rng(rng); b[63:32] = rng;
            rng = next_rng(rng);
            drive(a & b & (rng[8] ? ~64'h3 : 64'hFFFF_FFFF_FFFF_FFFF), int'(rng[1:0]), rng[2]);
            check_out("mixed pattern");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired R10 actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule